// File: doc/BRIEF.md
# Asynchronous PROM Bus Interface Controller

This block sits between a synchronous host and an asynchronous 8K x 8 one-time-programmable memory. It drives three active-low strobes (chip enable, output enable, program enable), a 13-bit address and the two halves of a bidirectional data bus: an output with an enable, and an input taken from the pads. The memory has no clock, so every access-time limit is turned into a count of clock cycles. The counts are worked out at elaboration from a clock-period parameter and a speed-grade parameter.

The host sends a request with a read/write flag, an address and write data, and the request is taken on a clock edge where `ready` is high. A read asserts chip enable and output enable and waits until the slowest access path has settled. It then captures the data and returns it with a one-cycle `rvalid` pulse. While the strobes are still asserted, a further read can be taken on that same sampling edge, and the controller then waits only for the address access time. When a read ends, the strobes are released and the controller waits for the memory outputs to float before it uses the bus again. A write selects program mode, drives the data for a set number of cycles and then returns to standby.

Top module: `prom_bus_ctrl`

## Requirements
- R1: During reset and after it, all three strobes are high (standby), the data output enable is low, `ready` is high and `rvalid` is low.
- R2: During a read, the strobes are chip enable low, output enable low and program enable high, and the data output enable stays low.
- R3: A read taken from standby samples the memory data on the clock edge that comes max(ceil(35/P), ceil(15/P)) cycles after the accepting edge, where P is the clock period in ns (5 cycles at the defaults of the fast grade and P = 8). The byte is presented on `rdata`, and `rvalid` is high for exactly the one cycle after that edge.
- R4: A read request taken on the sampling edge of a previous read keeps chip enable and output enable asserted and changes only the address. Its data is sampled ceil(35/P) cycles later (5 cycles at the defaults).
- R5: When a read ends with no read following it, chip enable and output enable go high together, and `ready` stays low for ceil(15/P) cycles (2 at the defaults) before standby accepts requests again.
- R6: A write selects program mode: chip enable low, program enable low, output enable high, with the data output enable high and the address and write data driven. This lasts PROG_CYCLES cycles (6 by default), then all strobes return high. A later read of that address returns the written byte.
- R7: The data output enable never rises while the memory may still drive the bus. A write taken on a read's sampling edge waits ceil(15/P) released-strobe cycles before program mode begins.
- R8: While `ready` is low, a pending request has no effect: the address at the memory pins and the strobe mode in progress do not change until the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| wr | input | 1 | 1 = program (write), 0 = read |
| addr | input | 13 | Host word address |
| wdata | input | 8 | Byte to program |
| ready | output | 1 | Request is taken on this edge when high |
| rdata | output | 8 | Byte returned by a read |
| rvalid | output | 1 | One-cycle pulse marking `rdata` valid |
| mem_addr | output | 13 | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pe_n | output | 1 | Program enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory pads |
| mem_dq_oe | output | 1 | Enable of the controller's data drivers |
| mem_dq_in | input | 8 | Data received from the memory pads |

## Verification
The checker watches the strobe encoding on every cycle. It confirms that output enable only appears in the read combination and that the data drivers only appear in program mode. It also confirms that a chained read keeps both enables low and that `ready` drops when output enable is released. A saturating counter inside the checker confirms that the drivers never turn on within the float window after output enable. The exact sampling cycles, the data returned, the length of program mode and the absence of bus contention all depend on a timed model of the memory, so only the bench scenarios can show them.

// File: rtl/prom_pkg.sv
`timescale 1ns/100ps
package prom_pkg;

  localparam int OE_ACCESS_NS = 15;
  localparam int FLOAT_NS     = 15;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_FLOAT = 2'd2,
    ST_PROG  = 2'd3
  } seq_state_t;

  // Address and chip-enable access time for a speed grade (0 fast, 1 slow).
  function automatic int grade_access_ns(input int grade);
    return (grade == 0) ? 35 : 45;
  endfunction

  // Whole clock cycles that cover a delay, never less than one.
  function automatic int ns_to_cycles(input int delay_ns, input int period_ns);
    int c;
    c = (delay_ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_seq.sv
`timescale 1ns/100ps
module prom_seq
  import prom_pkg::*;
#(
  parameter int W_FIRST     = 5,
  parameter int W_ADDR      = 5,
  parameter int W_FLOAT     = 2,
  parameter int PROG_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic ready,
  output logic accept,
  output logic sample_evt,
  output logic ce_n,
  output logic oe_n,
  output logic pe_n,
  output logic dq_oe
);

  localparam int MAXW  = max3(max2(W_FIRST, W_ADDR), W_FLOAT, PROG_CYCLES);
  localparam int CNT_W = (MAXW < 2) ? 1 : $clog2(MAXW);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign ready      = (state_q == ST_IDLE) || ((state_q == ST_READ) && cnt_zero);
  assign accept     = req && ready;
  assign sample_evt = (state_q == ST_READ) && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    case (state_q)
      ST_IDLE: begin
        if (accept && !wr) begin
          state_d = ST_READ;
          cnt_d   = CNT_W'(W_FIRST - 1);
        end else if (accept && wr) begin
          state_d = ST_PROG;
          cnt_d   = CNT_W'(PROG_CYCLES - 1);
        end
      end
      ST_READ: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (accept && !wr) begin
          cnt_d = CNT_W'(W_ADDR - 1);
        end else begin
          state_d = ST_FLOAT;
          cnt_d   = CNT_W'(W_FLOAT - 1);
          pend_d  = accept && wr;
        end
      end
      ST_FLOAT: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (pend_q) begin
          state_d = ST_PROG;
          cnt_d   = CNT_W'(PROG_CYCLES - 1);
          pend_d  = 1'b0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else           state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      pe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      ce_n    <= !((state_d == ST_READ) || (state_d == ST_PROG));
      oe_n    <= !(state_d == ST_READ);
      pe_n    <= !(state_d == ST_PROG);
      dq_oe   <= (state_d == ST_PROG);
    end
  end

endmodule

// File: rtl/prom_datapath.sv
`timescale 1ns/100ps
module prom_datapath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sample_evt,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= addr;
      if (wr) dq_out <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= sample_evt;
      if (sample_evt) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/prom_bus_ctrl.sv
`timescale 1ns/100ps
module prom_bus_ctrl
  import prom_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0,
  parameter int PROG_CYCLES   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int ACC_NS  = grade_access_ns(SPEED_GRADE);
  localparam int W_ADDR  = ns_to_cycles(ACC_NS, CLK_PERIOD_NS);
  localparam int W_CE    = ns_to_cycles(ACC_NS, CLK_PERIOD_NS);
  localparam int W_OE    = ns_to_cycles(OE_ACCESS_NS, CLK_PERIOD_NS);
  localparam int W_FIRST = max3(W_ADDR, W_CE, W_OE);
  localparam int W_FLOAT = ns_to_cycles(FLOAT_NS, CLK_PERIOD_NS);

  logic accept;
  logic accept_rd;
  logic sample_evt;

  assign accept_rd = accept && !wr;

  prom_seq #(
    .W_FIRST    (W_FIRST),
    .W_ADDR     (W_ADDR),
    .W_FLOAT    (W_FLOAT),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr        (wr),
    .ready     (ready),
    .accept    (accept),
    .sample_evt(sample_evt),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .pe_n      (mem_pe_n),
    .dq_oe     (mem_dq_oe)
  );

  prom_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .sample_evt(sample_evt),
    .dq_in     (mem_dq_in),
    .mem_addr  (mem_addr),
    .dq_out    (mem_dq_out),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

endmodule

// File: rtl/prom_bus_ctrl_chk.sv
`timescale 1ns/100ps
module prom_bus_ctrl_chk
  import prom_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_pe_n,
  input logic mem_dq_oe,
  input logic ready,
  input logic rvalid,
  input logic accept_rd
);

  localparam int FLOAT_CYC = ns_to_cycles(FLOAT_NS, CLK_PERIOD_NS);

  logic [7:0] since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since_oe <= 8'hFF;
    else if (!mem_oe_n)     since_oe <= 8'd0;
    else if (since_oe != 8'hFF) since_oe <= since_oe + 8'd1;
  end

  // R2: output enable only in the read combination
  a_r2_read_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_pe_n && !mem_dq_oe));

  // R6: drivers only in program mode
  a_r6_prog_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_pe_n && mem_oe_n));

  // R7: drivers wait out the float window
  a_r7_float_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (since_oe >= 8'(FLOAT_CYC)));

  // R4: chained read keeps both enables low
  a_r4_chain_keeps_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_rd && !mem_oe_n) |=> (!mem_oe_n && !mem_ce_n));

  // R5: releasing output enable drops ready
  a_r5_ready_low_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !ready);

  // R3: read data only follows a cycle with output enable asserted
  a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(!mem_oe_n));

endmodule

bind prom_bus_ctrl prom_bus_ctrl_chk #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_pe_n (mem_pe_n),
  .mem_dq_oe(mem_dq_oe),
  .ready    (ready),
  .rvalid   (rvalid),
  .accept_rd(accept_rd)
);

// File: tb/prom_bus_ctrl_test.sv
`timescale 1ns/100ps
module prom_bus_ctrl_test;

  localparam int TCLK     = 8;
  localparam int PROG_CYC = 6;
  localparam int ACC      = 35;
  localparam int WF_E     = (ACC + TCLK - 1) / TCLK;  // 5
  localparam int WA_E     = WF_E;
  localparam int FL_E     = (15 + TCLK - 1) / TCLK;   // 2

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid;
  logic [7:0]  rdata;
  logic [12:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_pe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int n_chk = 0, n_bad = 0, contention = 0;
  bit done = 0;

  logic [7:0] model_mem [0:8191];
  logic [7:0] exp_mem   [0:8191];

  always #(TCLK/2) clk = ~clk;

  prom_bus_ctrl #(.CLK_PERIOD_NS(TCLK), .PROG_CYCLES(PROG_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pe_n(mem_pe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- timed memory model ----------------
  real t_addr = -100.0, t_ce = -100.0, t_oe = -100.0, t_rd_end = -100.0;
  logic rd_on;
  assign rd_on = !mem_ce_n && !mem_oe_n && mem_pe_n;

  always @(mem_addr)         t_addr = $realtime;
  always @(negedge mem_ce_n) t_ce = $realtime;
  always @(negedge mem_oe_n) t_oe = $realtime;
  always @(negedge rd_on)    t_rd_end = $realtime;

  initial begin
    for (int i = 0; i < 8192; i++) begin
      model_mem[i] = 8'((i & 8'hFF) ^ ((i >> 5) * 3)) + 8'h3C;
      exp_mem[i]   = model_mem[i];
    end
    #0.3;
    forever begin
      real now;
      now = $realtime;
      if (rd_on && (now - t_addr >= ACC) && (now - t_ce >= ACC) && (now - t_oe >= 15.0))
        mem_dq_in = model_mem[mem_addr];
      else
        mem_dq_in = ~model_mem[mem_addr];
      if (mem_dq_oe && (rd_on || (now - t_rd_end < 15.0))) contention++;
      if (!mem_ce_n && !mem_pe_n && mem_oe_n && mem_dq_oe) model_mem[mem_addr] = mem_dq_out;
      #1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic n1_ce, n1_oe, n1_pe, n1_dqoe;

  task automatic do_read(input logic [12:0] a, output int lat, output logic [7:0] d);
    @(negedge clk); req = 1; wr = 0; addr = a;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); req = 0; lat = 1;
    n1_ce = mem_ce_n; n1_oe = mem_oe_n; n1_pe = mem_pe_n; n1_dqoe = mem_dq_oe;
    while (!rvalid && lat < 100) begin @(negedge clk); lat++; end
    d = rdata;
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d, output int pcyc);
    @(negedge clk); req = 1; wr = 1; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); req = 0; wr = 0; pcyc = 0;
    exp_mem[a] = d;
    while (mem_dq_oe && pcyc < 100) begin
      check(!mem_ce_n && !mem_pe_n && mem_oe_n && mem_addr == a && mem_dq_out == d,
            "R6 program mode pins", {mem_ce_n, mem_oe_n, mem_pe_n}, 3'b010);
      pcyc++; @(negedge clk);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_pe_n && !mem_dq_oe, "R1 strobes in reset",
          {mem_ce_n, mem_oe_n, mem_pe_n, mem_dq_oe}, 4'b1110);
    rst_n = 1;
    @(negedge clk);
    check(ready && !rvalid && mem_ce_n && mem_oe_n && mem_pe_n && !mem_dq_oe,
          "R1 idle after reset", {ready, rvalid, mem_ce_n, mem_dq_oe}, 4'b1010);
  endtask

  task automatic t_single_read(input logic [12:0] a);
    int lat; logic [7:0] d;
    do_read(a, lat, d);
    check(!n1_ce && !n1_oe && n1_pe && !n1_dqoe, "R2 read strobes",
          {n1_ce, n1_oe, n1_pe, n1_dqoe}, 4'b0010);
    check(lat == WF_E + 1, "R3 first read latency", lat, WF_E + 1);
    check(d == exp_mem[a], "R3 read data", d, exp_mem[a]);
    @(negedge clk);
    check(!rvalid, "R3 rvalid one cycle", rvalid, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_float(input logic [12:0] a);
    int lat; logic [7:0] d; int low;
    do_read(a, lat, d);
    check(mem_ce_n && mem_oe_n, "R5 strobes released", {mem_ce_n, mem_oe_n}, 2'b11);
    low = 0;
    while (!ready && low < 50) begin low++; @(negedge clk); end
    check(low == FL_E, "R5 float ready-low cycles", low, FL_E);
  endtask

  task automatic t_back_to_back(input logic [12:0] a0, input logic [12:0] a1,
                                input logic [12:0] a2);
    logic [12:0] seq_a [3];
    int lat;
    seq_a[0] = a0; seq_a[1] = a1; seq_a[2] = a2;
    @(negedge clk); req = 1; wr = 0; addr = a0;
    while (!ready) @(negedge clk);
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k < 2) addr = seq_a[k+1]; else req = 0;
      if (k > 0)
        check(rvalid && rdata == exp_mem[seq_a[k-1]], "R4 chained data",
              rdata, exp_mem[seq_a[k-1]]);
      lat = 1;
      while (!ready && lat < 100) begin
        check(mem_addr == seq_a[k], "R8 address held while stalled", mem_addr, seq_a[k]);
        check(!mem_ce_n && !mem_oe_n, "R4 strobes held", {mem_ce_n, mem_oe_n}, 0);
        @(negedge clk); lat++;
      end
      check(lat == ((k == 0) ? WF_E : WA_E), "R4 chained wait", lat, (k == 0) ? WF_E : WA_E);
      if (k < 2) @(posedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    check(rvalid && rdata == exp_mem[a2], "R4 last chained data", rdata, exp_mem[a2]);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_program(input logic [12:0] a, input logic [7:0] d);
    int pc, lat; logic [7:0] rd;
    do_write(a, d, pc);
    check(pc == PROG_CYC, "R6 program length", pc, PROG_CYC);
    check(mem_ce_n && mem_pe_n && mem_oe_n, "R6 back to standby",
          {mem_ce_n, mem_oe_n, mem_pe_n}, 3'b111);
    do_read(a, lat, rd);
    check(rd == d, "R6 readback", rd, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_write_after_read(input logic [12:0] a0, input logic [12:0] a1,
                                    input logic [7:0] d);
    int rel, pc, lat; logic [7:0] rd;
    @(negedge clk); req = 1; wr = 0; addr = a0;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); wr = 1; addr = a1; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); req = 0; wr = 0;
    exp_mem[a1] = d;
    check(rvalid && rdata == exp_mem[a0], "R7 read before write", rdata, exp_mem[a0]);
    rel = 0;
    while (!mem_dq_oe && rel < 50) begin
      if (mem_ce_n && mem_oe_n && mem_pe_n) rel++;
      @(negedge clk);
    end
    check(rel == FL_E, "R7 float cycles before drive", rel, FL_E);
    pc = 0;
    while (mem_dq_oe && pc < 100) begin pc++; @(negedge clk); end
    check(pc == PROG_CYC, "R7 program after float", pc, PROG_CYC);
    do_read(a1, lat, rd);
    check(rd == d, "R7 readback", rd, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_stall(input logic [12:0] a, input logic [7:0] d, input logic [12:0] b);
    int pc, lat;
    @(negedge clk); req = 1; wr = 1; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); wr = 0; addr = b;
    exp_mem[a] = d;
    pc = 0;
    while (mem_dq_oe && pc < 100) begin
      check(mem_addr == a && mem_oe_n && !mem_pe_n, "R8 program not disturbed",
            mem_addr, a);
      pc++; @(negedge clk);
    end
    check(pc == PROG_CYC, "R8 program length with pending read", pc, PROG_CYC);
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); req = 0; lat = 1;
    while (!rvalid && lat < 100) begin @(negedge clk); lat++; end
    check(rdata == exp_mem[b] && lat == WF_E + 1, "R8 stalled read served", rdata, exp_mem[b]);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_single_read(13'h0000);
    t_single_read(13'h1FFF);
    t_single_read(13'h0A5C);
    t_float(13'h0123);
    t_back_to_back(13'h0010, 13'h1F00, 13'h0011);
    t_program(13'h0777, 8'hA5);
    t_write_after_read(13'h0040, 13'h0041, 8'h5A);
    t_stall(13'h1234, 8'hC3, 13'h0042);
    check(contention == 0, "R7 no bus contention", contention, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(TCLK * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule